// File: doc/BRIEF.md
# Voice-Switched Attenuator Controller

This block sits in a hands-free voice path and acts on two linear PCM streams: the receive stream heading for the loudspeaker and the send stream coming from the microphone. For each sample it reduces the level of one of the two streams by about 6 dB. The choice depends on which side is talking. A small attenuator on each output makes echo less likely to build up into feedback.

A smoothed level detector watches each stream. A stream counts as active when its level rises above a programmable threshold. A hangover keeps the stream active for a while after the level falls, so the selection does not chatter. The attenuator choice comes from a fixed talk-state rule and is registered at the sample strobe. An active-low enable decides whether the controller attenuates at all. When the enable is high, both streams pass through untouched.

Top module: `vsw_att_ctrl`

## Requirements
- R1: When the receive stream is active and the send stream is silent after sample k, sample k+1 leaves on the send output attenuated and on the receive output unchanged (send flag high).
- R2: When the receive stream is silent after sample k, sample k+1 is attenuated on the receive output, whatever the state of the send stream (receive flag high).
- R3: When both streams are active after sample k, sample k+1 is attenuated on the receive output.
- R4: While `damp_en_ni` is low, exactly one of `rx_att_o`/`tx_att_o` is high with each output sample. The flagged path's output equals its input arithmetically shifted right by one bit, with the sign kept (for example -7 gives -4, -32768 gives -16384, 7 gives 3). The other path's output equals its input.
- R5: While `damp_en_ni` is high at a strobe, both output samples equal the inputs and both attenuator flags are low.
- R6: Each stream keeps an accumulator A that is updated at every strobe as A = A - (A >> 5) + |x|. Its level is A >> 5, and the level is above threshold when it is strictly greater than `thr_i`.
- R7: A stream's activity flag goes high at the strobe where the level first exceeds the threshold. It goes low only at the 64th consecutive strobe whose level is not above the threshold.
- R8: Outputs, flags and the selection change only at the clock edge where `smp_vld_i` is high. `out_vld_o` is high in the cycle after each strobe. The selection decided from sample k is applied to sample k+1.
- R9: Reset clears both accumulators and hangovers, selects the receive-output attenuator, drives both outputs to zero and drives all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe, one cycle per sample pair |
| rx_in_i | input | 16 | Receive stream sample, signed |
| tx_in_i | input | 16 | Send stream sample, signed |
| thr_i | input | 16 | Activity threshold on the smoothed level, unsigned |
| damp_en_ni | input | 1 | Attenuation enable, low enables, high bypasses both paths |
| rx_out_o | output | 16 | Processed receive sample, signed |
| tx_out_o | output | 16 | Processed send sample, signed |
| out_vld_o | output | 1 | Output samples updated in the previous edge |
| rx_act_o | output | 1 | Receive stream declared active |
| tx_act_o | output | 1 | Send stream declared active |
| rx_att_o | output | 1 | Current receive output was attenuated |
| tx_att_o | output | 1 | Current send output was attenuated |

## Verification
The talk-state rule is tried with four patterns: quiet on both sides, loud receive only, loud send only, and loud on both. Together they separate the single case that moves the attenuator to the send side from the three that keep it on the receive side. A loud burst followed by a long run of zeros measures the hangover length against the level decay. A short dip shows that the hangover bridges gaps. Odd negative values and the most negative code probe the rounding of the shift, a threshold set above the signal level shows the detector never triggers, and idle cycles with changing inputs between strobes show that nothing moves without a strobe.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

   typedef enum logic {
      SEL_RX = 1'b0,
      SEL_TX = 1'b1
   } sel_e;

   localparam int unsigned PATH_RX = 0;
   localparam int unsigned PATH_TX = 1;
   localparam int unsigned NPATH   = 2;

   function automatic sel_e talk_rule(input logic rx_act, input logic tx_act);
      return (rx_act && !tx_act) ? SEL_TX : SEL_RX;
   endfunction

endpackage

// File: rtl/vsw_level_det.sv
module vsw_level_det #(
   parameter int unsigned W        = 16,
   parameter int unsigned DECAY_SH = 5,
   parameter int unsigned HANG_N   = 64
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                stb_i,
   input  logic signed [W-1:0] smp_i,
   input  logic [W-1:0]        thr_i,
   output logic                act_o,
   output logic                act_nxt_o
);
   localparam int unsigned ACC_W = W + DECAY_SH + 1;
   localparam int unsigned HCW   = $clog2(HANG_N + 1);

   logic [W-1:0]     mag;
   logic [ACC_W-1:0] acc_q, acc_nxt, lvl;
   logic [HCW-1:0]   hang_q, hang_nxt;
   logic             above;

   always_comb begin
      mag     = smp_i[W-1] ? (~smp_i + 1'b1) : smp_i;
      acc_nxt = acc_q - (acc_q >> DECAY_SH) + ACC_W'(mag);
      lvl     = acc_nxt >> DECAY_SH;
      above   = lvl > ACC_W'(thr_i);
      if (above)
         hang_nxt = HCW'(HANG_N);
      else if (hang_q != '0)
         hang_nxt = hang_q - 1'b1;
      else
         hang_nxt = hang_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         hang_q <= '0;
      end else if (stb_i) begin
         acc_q  <= acc_nxt;
         hang_q <= hang_nxt;
      end
   end

   assign act_o     = (hang_q != '0);
   assign act_nxt_o = (hang_nxt != '0);

endmodule

// File: rtl/vsw_talk_sel.sv
module vsw_talk_sel
   import vsw_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stb_i,
   input  logic rx_act_i,
   input  logic tx_act_i,
   output sel_e sel_o
);
   sel_e sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         sel_q <= SEL_RX;
      else if (stb_i)
         sel_q <= talk_rule(rx_act_i, tx_act_i);
   end

   assign sel_o = sel_q;

endmodule

// File: rtl/vsw_atten.sv
module vsw_atten #(
   parameter int unsigned W  = 16,
   parameter int unsigned SH = 1
) (
   input  logic                en_i,
   input  logic signed [W-1:0] x_i,
   output logic signed [W-1:0] y_o
);
   if (SH == 0) begin : g_pass
      logic unused_en;
      assign unused_en = en_i;
      assign y_o       = x_i;
   end else begin : g_shift
      assign y_o = en_i ? (x_i >>> SH) : x_i;
   end

endmodule

// File: rtl/vsw_att_ctrl.sv
module vsw_att_ctrl
   import vsw_pkg::*;
#(
   parameter int unsigned SMP_W    = 16,
   parameter int unsigned DECAY_SH = 5,
   parameter int unsigned HANG_N   = 64,
   parameter int unsigned ATT_SH   = 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    smp_vld_i,
   input  logic signed [SMP_W-1:0] rx_in_i,
   input  logic signed [SMP_W-1:0] tx_in_i,
   input  logic [SMP_W-1:0]        thr_i,
   input  logic                    damp_en_ni,
   output logic signed [SMP_W-1:0] rx_out_o,
   output logic signed [SMP_W-1:0] tx_out_o,
   output logic                    out_vld_o,
   output logic                    rx_act_o,
   output logic                    tx_act_o,
   output logic                    rx_att_o,
   output logic                    tx_att_o
);
   if (SMP_W < 4)          begin : g_bad_w     $error("SMP_W must be at least 4");       end
   if (DECAY_SH < 1)       begin : g_bad_decay $error("DECAY_SH must be at least 1");    end
   if (HANG_N < 1)         begin : g_bad_hang  $error("HANG_N must be at least 1");      end
   if (ATT_SH >= SMP_W)    begin : g_bad_sh    $error("ATT_SH must be below SMP_W");     end

   logic signed [SMP_W-1:0] path_in  [NPATH];
   logic signed [SMP_W-1:0] path_att [NPATH];
   logic [NPATH-1:0]        path_act, path_act_nxt, path_en;
   sel_e                    sel_q;
   logic                    damp_on;

   assign path_in[PATH_RX] = rx_in_i;
   assign path_in[PATH_TX] = tx_in_i;
   assign damp_on          = !damp_en_ni;

   vsw_talk_sel i_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .stb_i    (smp_vld_i),
      .rx_act_i (path_act_nxt[PATH_RX]),
      .tx_act_i (path_act_nxt[PATH_TX]),
      .sel_o    (sel_q)
   );

   assign path_en[PATH_RX] = damp_on && (sel_q == SEL_RX);
   assign path_en[PATH_TX] = damp_on && (sel_q == SEL_TX);

   for (genvar p = 0; p < NPATH; p++) begin : g_path
      vsw_level_det #(
         .W        (SMP_W),
         .DECAY_SH (DECAY_SH),
         .HANG_N   (HANG_N)
      ) i_det (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .stb_i     (smp_vld_i),
         .smp_i     (path_in[p]),
         .thr_i     (thr_i),
         .act_o     (path_act[p]),
         .act_nxt_o (path_act_nxt[p])
      );

      vsw_atten #(
         .W  (SMP_W),
         .SH (ATT_SH)
      ) i_att (
         .en_i (path_en[p]),
         .x_i  (path_in[p]),
         .y_o  (path_att[p])
      );
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_out_o  <= '0;
         tx_out_o  <= '0;
         rx_att_o  <= 1'b0;
         tx_att_o  <= 1'b0;
         out_vld_o <= 1'b0;
      end else begin
         out_vld_o <= smp_vld_i;
         if (smp_vld_i) begin
            rx_out_o <= path_att[PATH_RX];
            tx_out_o <= path_att[PATH_TX];
            rx_att_o <= path_en[PATH_RX];
            tx_att_o <= path_en[PATH_TX];
         end
      end
   end

   assign rx_act_o = path_act[PATH_RX];
   assign tx_act_o = path_act[PATH_TX];

endmodule

// File: rtl/vsw_att_ctrl_chk.sv
module vsw_att_ctrl_chk
   import vsw_pkg::*;
#(
   parameter int unsigned SMP_W  = 16,
   parameter int unsigned ATT_SH = 1
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    smp_vld_i,
   input logic signed [SMP_W-1:0] rx_in_i,
   input logic signed [SMP_W-1:0] tx_in_i,
   input logic                    damp_en_ni,
   input logic signed [SMP_W-1:0] rx_out_o,
   input logic signed [SMP_W-1:0] tx_out_o,
   input logic                    out_vld_o,
   input logic                    rx_act_o,
   input logic                    tx_act_o,
   input logic                    rx_att_o,
   input logic                    tx_att_o,
   input sel_e                    sel_q
);
   // R4
   att_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rx_att_o, tx_att_o}));

   // R4
   att_engaged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && !$past(damp_en_ni)) |-> (rx_att_o != tx_att_o));

   // R5
   bypass_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && $past(damp_en_ni)) |-> (!rx_att_o && !tx_att_o));

   // R4
   rx_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && rx_att_o) |-> (rx_out_o == ($past(rx_in_i) >>> ATT_SH)));

   // R4
   tx_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && tx_att_o) |-> (tx_out_o == ($past(tx_in_i) >>> ATT_SH)));

   // R5
   rx_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && !rx_att_o) |-> (rx_out_o == $past(rx_in_i)));

   // R5
   tx_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_vld_o && !tx_att_o) |-> (tx_out_o == $past(tx_in_i)));

   // R1 R2 R3
   talk_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_vld_i |=> (sel_q == ((rx_act_o && !tx_act_o) ? SEL_TX : SEL_RX)));

   // R7
   rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rx_act_o) |-> $past(smp_vld_i));

   // R7
   tx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(tx_act_o) |-> $past(smp_vld_i));

   // R8
   out_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_vld_o == $past(smp_vld_i));

   // R8
   hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(smp_vld_i) |-> ($stable(rx_out_o) && $stable(tx_out_o) && $stable(sel_q)));

endmodule

bind vsw_att_ctrl vsw_att_ctrl_chk #(
   .SMP_W  (SMP_W),
   .ATT_SH (ATT_SH)
) i_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .smp_vld_i  (smp_vld_i),
   .rx_in_i    (rx_in_i),
   .tx_in_i    (tx_in_i),
   .damp_en_ni (damp_en_ni),
   .rx_out_o   (rx_out_o),
   .tx_out_o   (tx_out_o),
   .out_vld_o  (out_vld_o),
   .rx_act_o   (rx_act_o),
   .tx_act_o   (tx_act_o),
   .rx_att_o   (rx_att_o),
   .tx_att_o   (tx_att_o),
   .sel_q      (sel_q)
);

// File: tb/test_vsw_att_ctrl.sv
module test_vsw_att_ctrl;
   localparam int W     = 16;
   localparam int DECAY = 5;
   localparam int HANG  = 64;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                vld = 1'b0;
   logic signed [W-1:0] rx_in = '0, tx_in = '0;
   logic [W-1:0]        thr = 16'd1000;
   logic                en_n = 1'b0;
   logic signed [W-1:0] rx_out, tx_out;
   logic                out_vld, rx_act, tx_act, rx_att, tx_att;

   int n_chk = 0;
   int n_fail = 0;

   int m_acc [2];
   int m_hang [2];
   bit m_sel;

   always #5 clk = ~clk;

   vsw_att_ctrl i_vsw_att_ctrl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .smp_vld_i  (vld),
      .rx_in_i    (rx_in),
      .tx_in_i    (tx_in),
      .thr_i      (thr),
      .damp_en_ni (en_n),
      .rx_out_o   (rx_out),
      .tx_out_o   (tx_out),
      .out_vld_o  (out_vld),
      .rx_act_o   (rx_act),
      .tx_act_o   (tx_act),
      .rx_att_o   (rx_att),
      .tx_att_o   (tx_att)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int mag(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic model_reset();
      for (int p = 0; p < 2; p++) begin
         m_acc[p]  = 0;
         m_hang[p] = 0;
      end
      m_sel = 1'b0;
   endtask

   // one strobe; compares every output against the requirement model
   task automatic apply(input int rx, input int tx, input bit dis, input string tag);
      int  xs [2];
      bit  a_rx, a_tx;
      int  e_rx, e_tx;
      xs[0] = rx;
      xs[1] = tx;
      a_rx = !dis && !m_sel;
      a_tx = !dis && m_sel;
      e_rx = a_rx ? (rx >>> 1) : rx;
      e_tx = a_tx ? (tx >>> 1) : tx;
      for (int p = 0; p < 2; p++) begin
         m_acc[p] = m_acc[p] - (m_acc[p] >> DECAY) + mag(xs[p]);
         if ((m_acc[p] >> DECAY) > int'(thr)) m_hang[p] = HANG;
         else if (m_hang[p] > 0) m_hang[p]--;
      end
      @(negedge clk);
      rx_in = W'(rx);
      tx_in = W'(tx);
      en_n  = dis;
      vld   = 1'b1;
      @(negedge clk);
      vld = 1'b0;
      m_sel = (m_hang[0] != 0) && (m_hang[1] == 0);
      check(tag, "rx_out", int'(rx_out), e_rx);
      check(tag, "tx_out", int'(tx_out), e_tx);
      check(tag, "rx_att", int'(rx_att), int'(a_rx));
      check(tag, "tx_att", int'(tx_att), int'(a_tx));
      check(tag, "rx_act", int'(rx_act), int'(m_hang[0] != 0));
      check(tag, "tx_act", int'(tx_act), int'(m_hang[1] != 0));
      check(tag, "out_vld", int'(out_vld), 1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9", "rx_out", int'(rx_out), 0);
      check("R9", "tx_out", int'(tx_out), 0);
      check("R9", "flags", int'({out_vld, rx_act, tx_act, rx_att, tx_att}), 0);
      rst_n = 1'b1;
      model_reset();
      // first sample after reset goes through the receive attenuator
      apply(1001, -1001, 1'b0, "R9");
   endtask

   task automatic t_quiet();
      for (int i = 0; i < 8; i++) apply(300 - 77 * i, -250 + 61 * i, 1'b0, "R2");
   endtask

   task automatic t_rx_only();
      for (int i = 0; i < 20; i++) apply((i % 2) ? 20000 : -20000, 40, 1'b0, "R1");
   endtask

   task automatic t_double();
      for (int i = 0; i < 20; i++) apply(18000, (i % 2) ? -21000 : 21000, 1'b0, "R3");
   endtask

   task automatic t_tx_only();
      for (int i = 0; i < 90; i++) apply(0, (i % 2) ? 25000 : -25000, 1'b0, "R2");
   endtask

   task automatic t_hang();
      int cnt;
      for (int i = 0; i < 90; i++) apply(0, 0, 1'b0, "R7");
      for (int i = 0; i < 10; i++) apply(22000, 0, 1'b0, "R7");
      // short gap, bridged by the hangover
      for (int i = 0; i < 20; i++) apply(0, 0, 1'b0, "R7");
      check("R7", "rx_act during gap", int'(rx_act), 1);
      for (int i = 0; i < 10; i++) apply(-22000, 0, 1'b0, "R7");
      cnt = 0;
      for (int i = 0; i < 150; i++) begin
         apply(0, 0, 1'b0, "R7");
         if (rx_act) cnt++;
      end
      check("R7", "rx_act after decay", int'(rx_act), 0);
   endtask

   task automatic t_round();
      apply(-7, 5, 1'b0, "R4");
      apply(7, -5, 1'b0, "R4");
      apply(-1, 1, 1'b0, "R4");
      apply(-32768, 32767, 1'b0, "R4");
      for (int i = 0; i < 6; i++) apply(30000, -7, 1'b0, "R4");
      apply(30000, -32768, 1'b0, "R4");
      apply(30000, -1, 1'b0, "R4");
   endtask

   task automatic t_bypass();
      for (int i = 0; i < 10; i++) apply(24000 - 1000 * i, -333 + i, 1'b1, "R5");
   endtask

   task automatic t_level();
      for (int i = 0; i < 100; i++) apply(0, 0, 1'b0, "R6");
      thr = 16'd30000;
      for (int i = 0; i < 40; i++) apply(20000, -100, 1'b0, "R6");
      check("R6", "rx_act high thr", int'(rx_act), 0);
      thr = 16'd100;
      for (int i = 0; i < 5; i++) apply(4000, 0, 1'b0, "R6");
      thr = 16'd1000;
   endtask

   task automatic t_hold();
      logic signed [W-1:0] h_rx, h_tx;
      logic                h_ra, h_ta;
      apply(12345, -2222, 1'b0, "R8");
      h_rx = rx_out; h_tx = tx_out; h_ra = rx_att; h_ta = tx_att;
      for (int i = 0; i < 5; i++) begin
         rx_in = W'(777 * i);
         tx_in = W'(-999 * i);
         @(negedge clk);
         check("R8", "out_vld idle", int'(out_vld), 0);
         check("R8", "rx_out held", int'(rx_out), int'(h_rx));
         check("R8", "tx_out held", int'(tx_out), int'(h_tx));
         check("R8", "att held", int'({rx_att, tx_att}), int'({h_ra, h_ta}));
      end
      apply(-4321, 100, 1'b0, "R8");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_quiet();
      t_rx_only();
      t_double();
      t_tx_only();
      t_hang();
      t_round();
      t_bypass();
      t_level();
      t_hold();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule